// File: doc/BRIEF.md
# Periodic Four-Channel DAC Refresh Sequencer

This block keeps four DAC channels refreshed at a fixed sample rate. A host writes a 12-bit level into any channel's holding register at any time through a simple write port. An internal divider turns the system clock into a sample tick. Each tick starts one refresh pass. The pass copies all four held levels into a snapshot. It then asks a separate serial frame engine for one frame per channel, in the fixed order 0, 1, 2, 3, and waits for each frame to complete before it asks for the next.

The frame engine reports a readback word with each completed frame. The block keeps the most recent one. At the end of a pass, that word is the echo of the command the converter had executed before the last frame. A pass takes the same number of cycles whatever the data, so the analogue samples carry no timing jitter.

The converter output is k/4096 of the reference for its channel pair. Channels 0 and 1 share one reference and channels 2 and 3 share another, so code 12'hFFF stays one step below full reference. A tick that arrives while a pass is still running is dropped and raises a sticky overrun flag.

Top module: `dac_refresh_seq`

## Requirements
- R1: The sample tick recurs every CLK_HZ/SAMPLE_HZ clock cycles. A tick that arrives while the block is idle starts a pass in the same cycle, so the first frame requests of two consecutive passes are exactly that many cycles apart.
- R2: Within a pass, frames are requested for channel codes 0, 1, 2 and 3 in that order, with the level held for each channel.
- R3: `frm_req` is a single-cycle pulse, and `busy` is high whenever it is asserted. A pass raises `busy` in the same cycle as the channel-0 request. No further request is made until `frm_done` has been seen for the current frame.
- R4: All four levels are snapshotted when the pass starts. A host write during a pass has no effect on that pass, and `frm_val` stays steady while the channel does not change. The new value appears in the next pass.
- R5: A cycle with `wr_en` high stores `wr_val` into the holding register selected by `wr_chan` (code 0 to 3).
- R6: Each `frm_done` accepted while waiting loads `frm_rdata` into `rdbk`, and `rdbk` changes at no other time. After a pass, `rdbk` holds the readback of that pass's fourth frame.
- R7: `pass_done` is high for exactly one clock, in the cycle after the fourth frame's `frm_done`.
- R8: The pass length, from the first request to `pass_done`, depends only on the frame engine's latency and not on the channel levels.
- R9: A tick that occurs while `busy` is high sets `overrun`, which stays set until reset. That tick starts no pass.
- R10: A `frm_done` pulse while the block is idle does not change `rdbk`, does not raise `pass_done` and does not start a pass.
- R11: After reset, `busy`, `frm_req`, `pass_done` and `overrun` are low, `rdbk` is zero, and all holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_chan | input | 2 | Channel code of the host write |
| wr_val | input | 12 | Level written by the host |
| frm_req | output | 1 | One-cycle request for a frame to the engine |
| frm_chan | output | 2 | Channel code of the requested frame |
| frm_val | output | 12 | Level of the requested frame |
| frm_done | input | 1 | Frame engine completion pulse |
| frm_rdata | input | 32 | Readback word returned with `frm_done` |
| rdbk | output | 32 | Most recent readback word |
| busy | output | 1 | A pass is in progress |
| pass_done | output | 1 | One-clock pulse at the end of a pass |
| overrun | output | 1 | Sticky flag: a tick arrived during a pass |

## Verification
The bench builds the block with CLK_HZ = 480000 and SAMPLE_HZ = 8000, which makes the tick period 60 cycles. Many passes therefore fit in a short run, and the exact spacing of pass starts can be compared cycle for cycle. The frame engine model has a settable latency. At 3 cycles a pass ends well inside one period. At 20 cycles a pass lasts 88 cycles, so a tick lands mid-pass, which exercises the overrun flag and shows that the next pass starts two periods later.

// File: rtl/dac_seq_pkg.sv
// Shared types for the DAC refresh sequencer.
// Assumes: nothing beyond the SystemVerilog language.
package dac_seq_pkg;

    // Pass controller states.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/dac_tick_div.sv
// Sample tick divider: emits a one-cycle pulse every DIV clocks.
// Assumes: DIV >= 2; counts from reset release.
module dac_tick_div #(
    parameter int DIV = 15625
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dac_hold_bank.sv
// Holding registers for every channel, plus a snapshot copy taken at the
// start of a pass. The snapshot feeds the frame engine.
// Assumes: if a write and a snapshot fall in the same cycle, the snapshot
// takes the value stored before that write.
module dac_hold_bank #(
    parameter int NCH   = 4,
    parameter int VAL_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NCH)-1:0]   wr_chan,
    input  logic [VAL_W-1:0]         wr_val,
    input  logic                     snap,
    input  logic [$clog2(NCH)-1:0]   sel,
    output logic [VAL_W-1:0]         sel_val
);
    localparam int CH_W = $clog2(NCH);

    logic [VAL_W-1:0] live [NCH];
    logic [VAL_W-1:0] held [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Host-side store for channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                live[g] <= '0;
            else if (wr_en && (wr_chan == CH_W'(g)))
                live[g] <= wr_val;
        end

        // Pass-start snapshot for channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[g] <= '0;
            else if (snap)
                held[g] <= live[g];
        end
    end

    assign sel_val = held[sel];
endmodule

// File: rtl/dac_pass_ctrl.sv
// Pass controller: on a tick it walks the channels in ascending order,
// issuing one request pulse per frame and waiting for the engine to finish.
// It captures readback, flags overruns and marks the end of a pass.
// Assumes: frm_done is a single-cycle pulse from the frame engine.
module dac_pass_ctrl
    import dac_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int RB_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   frm_done,
    input  logic [RB_W-1:0]        frm_rdata,
    output logic                   snap,
    output logic                   frm_req,
    output logic [$clog2(NCH)-1:0] chan,
    output logic [RB_W-1:0]        rdbk,
    output logic                   busy,
    output logic                   pass_done,
    output logic                   overrun
);
    localparam int CH_W = $clog2(NCH);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    seq_state_t st;

    assign snap    = (st == SEQ_IDLE) && tick;
    assign frm_req = (st == SEQ_ISSUE);
    assign busy    = (st != SEQ_IDLE);

    // Sequence the channels, capture readback, raise the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SEQ_IDLE;
            chan      <= '0;
            rdbk      <= '0;
            pass_done <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            pass_done <= 1'b0;
            if (tick && (st != SEQ_IDLE))
                overrun <= 1'b1;
            case (st)
                SEQ_IDLE: begin
                    if (tick) begin
                        chan <= '0;
                        st   <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: st <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (frm_done) begin
                        rdbk <= frm_rdata;
                        if (chan == LAST_CH) begin
                            st        <= SEQ_IDLE;
                            pass_done <= 1'b1;
                        end else begin
                            chan <= chan + 1'b1;
                            st   <= SEQ_ISSUE;
                        end
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dac_refresh_seq.sv
// Top of the DAC refresh sequencer: tick divider, holding bank and pass
// controller. The serial frame engine sits outside this block.
// Assumes: CLK_HZ is an integer multiple of SAMPLE_HZ and at least twice it.
module dac_refresh_seq #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int SAMPLE_HZ = 8000,
    parameter int NCH       = 4,
    parameter int VAL_W     = 12,
    parameter int RB_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)-1:0] wr_chan,
    input  logic [VAL_W-1:0]       wr_val,
    output logic                   frm_req,
    output logic [$clog2(NCH)-1:0] frm_chan,
    output logic [VAL_W-1:0]       frm_val,
    input  logic                   frm_done,
    input  logic [RB_W-1:0]        frm_rdata,
    output logic [RB_W-1:0]        rdbk,
    output logic                   busy,
    output logic                   pass_done,
    output logic                   overrun
);
    localparam int DIV = CLK_HZ / SAMPLE_HZ;

    logic tick;
    logic snap;

    dac_tick_div #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    dac_hold_bank #(.NCH(NCH), .VAL_W(VAL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_chan(wr_chan),
        .wr_val (wr_val),
        .snap   (snap),
        .sel    (frm_chan),
        .sel_val(frm_val)
    );

    dac_pass_ctrl #(.NCH(NCH), .RB_W(RB_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .frm_done (frm_done),
        .frm_rdata(frm_rdata),
        .snap     (snap),
        .frm_req  (frm_req),
        .chan     (frm_chan),
        .rdbk     (rdbk),
        .busy     (busy),
        .pass_done(pass_done),
        .overrun  (overrun)
    );
endmodule

// File: rtl/dac_refresh_seq_chk.sv
// Port-level protocol checker for dac_refresh_seq, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module dac_refresh_seq_chk #(
    parameter int NCH   = 4,
    parameter int VAL_W = 12,
    parameter int RB_W  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frm_req,
    input logic [$clog2(NCH)-1:0] frm_chan,
    input logic [VAL_W-1:0]       frm_val,
    input logic                   frm_done,
    input logic [RB_W-1:0]        rdbk,
    input logic                   busy,
    input logic                   pass_done,
    input logic                   overrun
);
    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req |=> !frm_req);

    assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req |-> busy);

    assert_start_chan0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (frm_req && frm_chan == '0));

    assert_val_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && frm_chan == $past(frm_chan)) |-> $stable(frm_val));

    assert_rdbk_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdbk) |-> $past(frm_done));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    assert_done_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> ($past(frm_done) && !busy));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind dac_refresh_seq dac_refresh_seq_chk #(
    .NCH(NCH), .VAL_W(VAL_W), .RB_W(RB_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_req  (frm_req),
    .frm_chan (frm_chan),
    .frm_val  (frm_val),
    .frm_done (frm_done),
    .rdbk     (rdbk),
    .busy     (busy),
    .pass_done(pass_done),
    .overrun  (overrun)
);

// File: tb/test_dac_refresh_seq.sv
// Directed bench for dac_refresh_seq with a frame engine model of settable
// latency. The model echoes the previous frame's command word as readback.
module test_dac_refresh_seq;
    localparam int CLK_HZ    = 480_000;
    localparam int SAMPLE_HZ = 8000;
    localparam int DIV       = CLK_HZ / SAMPLE_HZ;
    localparam int LOGN      = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [11:0] wr_val = '0;
    logic        frm_req;
    logic [1:0]  frm_chan;
    logic [11:0] frm_val;
    logic        frm_done;
    logic [31:0] frm_rdata;
    logic [31:0] rdbk;
    logic        busy, pass_done, overrun;

    logic        m_done = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [31:0] m_prev = '0;
    logic [31:0] m_cur = '0;
    int          m_cnt = 0;
    int          lat = 3;
    logic        stray = 1'b0;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    int          ev_n = 0;
    logic [1:0]  ev_chan [LOGN];
    logic [11:0] ev_val  [LOGN];
    int          ev_cyc  [LOGN];
    int          pd_n = 0;
    int          pd_cyc  [LOGN];
    int          last_done = 0;
    logic        pd_prev = 1'b0;
    int          pd_wide = 0;

    assign frm_done  = m_done | stray;
    assign frm_rdata = stray ? 32'hDEAD_BEEF : m_rdata;

    always #4 clk = ~clk;

    dac_refresh_seq #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ)) i_dac_refresh_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_val(wr_val),
        .frm_req(frm_req), .frm_chan(frm_chan), .frm_val(frm_val),
        .frm_done(frm_done), .frm_rdata(frm_rdata), .rdbk(rdbk),
        .busy(busy), .pass_done(pass_done), .overrun(overrun)
    );

    function automatic logic [31:0] cmd_word(input logic [1:0] ch, input logic [11:0] v);
        return {8'h00, 4'h3, 2'b00, ch, v, 4'h0};
    endfunction

    // Frame engine model: fixed latency, echoes previous command word.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_done <= 1'b0; m_cnt <= 0; m_prev <= '0; m_rdata <= '0;
        end else begin
            m_done <= 1'b0;
            if (m_cnt > 0) begin
                if (m_cnt == 1) begin
                    m_done  <= 1'b1;
                    m_rdata <= m_prev;
                    m_prev  <= m_cur;
                end
                m_cnt <= m_cnt - 1;
            end
            if (frm_req) begin
                m_cur <= cmd_word(frm_chan, frm_val);
                m_cnt <= lat;
            end
        end
    end

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_req && ev_n < LOGN) begin
                ev_chan[ev_n] = frm_chan; ev_val[ev_n] = frm_val; ev_cyc[ev_n] = cyc;
                ev_n = ev_n + 1;
            end
            if (m_done) last_done = cyc;
            if (pass_done && pd_n < LOGN) begin
                pd_cyc[pd_n] = cyc; pd_n = pd_n + 1;
            end
            if (pass_done && pd_prev) pd_wide = pd_wide + 1;
            pd_prev = pass_done;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] ch, input logic [11:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = ch; wr_val = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pass(output int idx);
        int n0 = pd_n;
        while (pd_n == n0) @(negedge clk);
        idx = pd_n - 1;
    endtask

    // R11: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R11 busy", busy, 0);
        check(frm_req == 1'b0, "R11 frm_req", frm_req, 0);
        check(pass_done == 1'b0 && overrun == 1'b0, "R11 flags", {pass_done, overrun}, 0);
        check(rdbk == 32'h0, "R11 rdbk", rdbk, 0);
        rst_n = 1'b1;
    endtask

    // R2 R5 R6 R7: one full pass with written values.
    task automatic t_order(input logic [11:0] a, input logic [11:0] b,
                           input logic [11:0] c, input logic [11:0] d, output int p);
        logic [11:0] exp [4];
        exp[0] = a; exp[1] = b; exp[2] = c; exp[3] = d;
        while (busy) @(negedge clk);
        host_write(2'd0, a); host_write(2'd1, b); host_write(2'd2, c); host_write(2'd3, d);
        while (busy) @(negedge clk);
        begin
            int base = ev_n;
            wait_pass(p);
            check(ev_n - base == 4, "R3 four requests per pass", ev_n - base, 4);
            for (int k = 0; k < 4; k++) begin
                check(ev_chan[base + k] == 2'(k), "R2 channel order", ev_chan[base + k], k);
                check(ev_val[base + k] == exp[k], "R5 level per channel", ev_val[base + k], exp[k]);
            end
            @(negedge clk);
            check(rdbk == cmd_word(2'd2, c), "R6 readback after pass", rdbk, cmd_word(2'd2, c));
            check(pd_cyc[p] == last_done + 1, "R7 pass_done timing", pd_cyc[p], last_done + 1);
            check(pd_wide == 0, "R7 pass_done width", pd_wide, 0);
        end
    endtask

    // R1 R8: period and data-independent pass length.
    task automatic t_period();
        int p1, p2, s1, s2;
        t_order(12'h000, 12'h000, 12'h000, 12'h000, p1);
        s1 = ev_n - 4;
        t_order(12'hFFF, 12'h5A5, 12'hA5A, 12'hFFF, p2);
        s2 = ev_n - 4;
        check(((ev_cyc[s2] - ev_cyc[s1]) % DIV) == 0 && ev_cyc[s2] > ev_cyc[s1],
              "R1 pass start on tick grid", ev_cyc[s2] - ev_cyc[s1], DIV);
        check(pd_cyc[p1] - ev_cyc[s1] == pd_cyc[p2] - ev_cyc[s2], "R8 fixed pass length",
              pd_cyc[p2] - ev_cyc[s2], pd_cyc[p1] - ev_cyc[s1]);
        begin
            int base = ev_n, p;
            wait_pass(p);
            check(ev_cyc[base] - ev_cyc[s2] == DIV, "R1 tick period",
                  ev_cyc[base] - ev_cyc[s2], DIV);
        end
    endtask

    // R4: write during a pass affects only the next pass.
    task automatic t_snapshot();
        int base, p;
        host_write(2'd3, 12'h111);
        while (busy) @(negedge clk);
        base = ev_n;
        while (!frm_req) @(negedge clk);
        host_write(2'd3, 12'h999);
        wait_pass(p);
        check(ev_val[base + 3] == 12'h111, "R4 snapshot holds old value", ev_val[base + 3], 12'h111);
        base = ev_n;
        wait_pass(p);
        check(ev_val[base + 3] == 12'h999, "R4 new value next pass", ev_val[base + 3], 12'h999);
    endtask

    // R10: stray completion while idle.
    task automatic t_stray();
        int p, n0, e0;
        logic [31:0] rb;
        wait_pass(p);
        @(negedge clk);
        rb = rdbk; n0 = pd_n; e0 = ev_n;
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        repeat (3) @(negedge clk);
        check(rdbk == rb, "R10 rdbk unchanged", rdbk, rb);
        check(pd_n == n0 && busy == 1'b0 && ev_n == e0, "R10 no pass", pd_n, n0);
    endtask

    // R9: slow engine, tick mid-pass.
    task automatic t_overrun();
        int p, base;
        while (busy) @(negedge clk);
        check(overrun == 1'b0, "R9 no overrun before", overrun, 0);
        lat = 20;
        base = ev_n;
        wait_pass(p);
        check(overrun == 1'b1, "R9 overrun set", overrun, 1);
        wait_pass(p);
        check(ev_cyc[base + 4] - ev_cyc[base] == 2 * DIV, "R9 tick dropped",
              ev_cyc[base + 4] - ev_cyc[base], 2 * DIV);
        check(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    endtask

    initial begin
        int p;
        @(negedge clk);
        t_reset();
        t_order(12'h123, 12'h456, 12'h789, 12'hABC, p);
        t_period();
        t_snapshot();
        t_stray();
        t_overrun();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule